// File: doc/BRIEF.md
# Sort-and-Route Cell Fabric

This block moves fixed-size cells from N input ports to N output ports, with N a power of two (eight by default). Each input carries a valid flag, a destination port number and a payload. A self-routing shuffle-exchange network can lose cells when two of them need the same switch output at the same time. To prevent this, the fabric first orders the valid cells by destination in a bitonic merge sorter. It then removes every cell whose destination is already taken by a lower-numbered input and packs the survivors into the lowest positions without gaps. After that, the routing network delivers every surviving cell without internal conflict.

The fabric also settles contention between inputs. A discarded cell raises the reject flag of the input it came from, in the same cycle as the winners appear at the outputs, so an upstream queue can present it again. Multicast, input queueing and any fairness policy belong to the logic around the block.

Top module: `sortroute_fabric`

## Requirements
- R1: While rst_n is low, out_valid, out_data and in_reject are all zero.
- R2: With IN_REG = 0, outputs show the result for the inputs present at the previous rising clock edge. With IN_REG = 1 they show the result for the inputs two edges back.
- R3: Input i uses bits in_addr[i*AW +: AW] as its destination and bits in_data[i*DW +: DW] as its payload. Every valid cell that is not rejected appears exactly once, at output port p equal to its destination, with out_valid[p] = 1 and its payload in out_data[p*DW +: DW].
- R4: When several valid cells share a destination, the cell from the lowest-numbered input is delivered. Each of the others sets its own bit of in_reject.
- R5: An idle input (in_valid bit 0) never sets its reject bit and causes no output. An output port that no valid cell addresses shows out_valid = 0 and zero data.
- R6: In each result, the number of set out_valid bits plus the number of set in_reject bits equals the number of valid inputs.
- R7: No two cells ever compete for the same output of a 2x2 element inside the routing network.
- R8: Idle, 2, 2, idle, 3, idle, idle, idle on inputs 0 to 7 delivers input 1 at port 2 and input 4 at port 3, and rejects input 2 only.
- R9: When all inputs are valid with one destination, only input 0 is delivered and inputs 1 to N-1 are rejected.
- R10: When all inputs are valid with distinct destinations, all N cells are delivered and none is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | One valid flag per input port |
| in_addr | input | N*AW | Destination port for each input |
| in_data | input | N*DW | Payload for each input |
| out_valid | output | N | A cell is present at that output port |
| out_data | output | N*DW | Payload for each output port |
| in_reject | output | N | The cell on that input lost contention and was dropped |

## Verification
The bench builds the fabric with AW = 3, DW = 8 and IN_REG = 1. This gives eight ports, a three-stage routing network and the registered-input variant, so the two-cycle latency path and the bitonic network at full depth are both covered. The address width allows patterns that touch every output. The 8-bit payload leaves room to tag each cell with its input number, so a cell that is misrouted, duplicated or lost shows up as wrong data. Random traffic is mixed with narrow address ranges, which produce many duplicate destinations.

// File: rtl/fab_pkg.sv
package fab_pkg;
   // Perfect shuffle: rotate a port index left by one bit within aw bits.
   function automatic int unsigned shuffle_pos(input int unsigned p, input int unsigned aw);
      int unsigned msk;
      msk = (32'd1 << aw) - 32'd1;
      return ((p << 1) | (p >> (aw - 1))) & msk;
   endfunction
endpackage

// File: rtl/fab_sorter.sv
module fab_sorter #(
   parameter int AW = 3,
   parameter int DW = 8,
   localparam int N = 1 << AW
) (
   input  logic [N-1:0]    v_i,
   input  logic [N*AW-1:0] a_i,
   input  logic [N*DW-1:0] d_i,
   output logic [N-1:0]    v_o,
   output logic [N*AW-1:0] a_o,
   output logic [N*AW-1:0] src_o,
   output logic [N*DW-1:0] d_o
);
   // Key: idle flag on top so idle cells sort last, then destination,
   // then source index so equal destinations keep input order.
   localparam int KW = 1 + 2 * AW;

   logic [KW-1:0] key [N];
   logic [DW-1:0] dat [N];
   logic [KW-1:0] tk;
   logic [DW-1:0] td;
   logic          up;

   always_comb begin
      tk = '0;
      td = '0;
      up = 1'b0;
      for (int i = 0; i < N; i++) begin
         key[i] = {~v_i[i], a_i[i*AW +: AW], AW'(i)};
         dat[i] = d_i[i*DW +: DW];
      end
      for (int k = 2; k <= N; k = k * 2) begin
         for (int j = k / 2; j > 0; j = j / 2) begin
            for (int i = 0; i < N; i++) begin
               if ((i ^ j) > i) begin
                  up = ((i & k) == 0);
                  if ((key[i] > key[i ^ j]) == up) begin
                     tk = key[i];
                     key[i] = key[i ^ j];
                     key[i ^ j] = tk;
                     td = dat[i];
                     dat[i] = dat[i ^ j];
                     dat[i ^ j] = td;
                  end
               end
            end
         end
      end
      for (int i = 0; i < N; i++) begin
         v_o[i]             = ~key[i][KW-1];
         a_o[i*AW +: AW]    = key[i][2*AW-1:AW];
         src_o[i*AW +: AW]  = key[i][AW-1:0];
         d_o[i*DW +: DW]    = dat[i];
      end
   end
endmodule

// File: rtl/fab_compact.sv
module fab_compact #(
   parameter int AW = 3,
   parameter int DW = 8,
   localparam int N = 1 << AW
) (
   input  logic [N-1:0]    v_i,
   input  logic [N*AW-1:0] a_i,
   input  logic [N*AW-1:0] src_i,
   input  logic [N*DW-1:0] d_i,
   output logic [N-1:0]    v_o,
   output logic [N*AW-1:0] a_o,
   output logic [N*DW-1:0] d_o,
   output logic [N-1:0]    drop_o
);
   // Sorted input: a cell repeating its predecessor's destination loses;
   // survivors are packed to positions 0..K-1 in sorted order.
   int            rank;
   logic          pv;
   logic [AW-1:0] pa;

   always_comb begin
      v_o    = '0;
      a_o    = '0;
      d_o    = '0;
      drop_o = '0;
      rank   = 0;
      pv     = 1'b0;
      pa     = '0;
      for (int i = 0; i < N; i++) begin
         if (v_i[i]) begin
            if (pv && (a_i[i*AW +: AW] == pa)) begin
               drop_o[src_i[i*AW +: AW]] = 1'b1;
            end else begin
               v_o[rank]            = 1'b1;
               a_o[rank*AW +: AW]   = a_i[i*AW +: AW];
               d_o[rank*DW +: DW]   = d_i[i*DW +: DW];
               rank                 = rank + 1;
            end
         end
         pv = v_i[i];
         pa = a_i[i*AW +: AW];
      end
   end
endmodule

// File: rtl/fab_omega.sv
module fab_omega #(
   parameter int AW = 3,
   parameter int DW = 8,
   localparam int N = 1 << AW
) (
   input  logic [N-1:0]    v_i,
   input  logic [N*AW-1:0] a_i,
   input  logic [N*DW-1:0] d_i,
   output logic [N-1:0]    v_o,
   output logic [N*DW-1:0] d_o,
   output logic            clash_o
);
   import fab_pkg::*;

   logic [AW-1:0] hits;

   for (genvar s = 0; s < AW; s++) begin : g_st
      logic [N-1:0]    iv, hv, ov;
      logic [N*AW-1:0] ia, ha, oa;
      logic [N*DW-1:0] id, hd, od;
      logic            hit;

      if (s == 0) begin : g_in
         assign iv = v_i;
         assign ia = a_i;
         assign id = d_i;
      end else begin : g_in
         assign iv = g_st[s-1].ov;
         assign ia = g_st[s-1].oa;
         assign id = g_st[s-1].od;
      end

      // Shuffle wiring ahead of this column of 2x2 elements.
      always_comb begin
         hv = '0;
         ha = '0;
         hd = '0;
         for (int p = 0; p < N; p++) begin
            hv[shuffle_pos(p, AW)]         = iv[p];
            ha[shuffle_pos(p, AW)*AW +: AW] = ia[p*AW +: AW];
            hd[shuffle_pos(p, AW)*DW +: DW] = id[p*DW +: DW];
         end
      end

      // Element m: destination bit 0 -> even (upper) output, 1 -> odd (lower).
      always_comb begin
         ov  = '0;
         oa  = '0;
         od  = '0;
         hit = 1'b0;
         for (int m = 0; m < N / 2; m++) begin
            for (int t = 0; t < 2; t++) begin
               if (hv[2*m+t]) begin
                  if (ov[2*m + int'(ha[(2*m+t)*AW + (AW-1-s)])]) begin
                     hit = 1'b1;
                  end else begin
                     ov[2*m + int'(ha[(2*m+t)*AW + (AW-1-s)])]            = 1'b1;
                     oa[(2*m + int'(ha[(2*m+t)*AW + (AW-1-s)]))*AW +: AW] = ha[(2*m+t)*AW +: AW];
                     od[(2*m + int'(ha[(2*m+t)*AW + (AW-1-s)]))*DW +: DW] = hd[(2*m+t)*DW +: DW];
                  end
               end
            end
         end
      end

      assign hits[s] = hit;
   end

   assign v_o     = g_st[AW-1].ov;
   assign d_o     = g_st[AW-1].od;
   assign clash_o = |hits;
endmodule

// File: rtl/sortroute_fabric.sv
module sortroute_fabric #(
   parameter int AW     = 3,
   parameter int DW     = 8,
   parameter bit IN_REG = 1'b0,
   localparam int N = 1 << AW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    in_valid,
   input  logic [N*AW-1:0] in_addr,
   input  logic [N*DW-1:0] in_data,
   output logic [N-1:0]    out_valid,
   output logic [N*DW-1:0] out_data,
   output logic [N-1:0]    in_reject
);
   if (AW < 1 || AW > 5) begin : g_bad_aw
      $error("sortroute_fabric: AW must lie in 1..5");
   end
   if (DW < 1) begin : g_bad_dw
      $error("sortroute_fabric: DW must be at least 1");
   end

   logic [N-1:0]    core_v;
   logic [N*AW-1:0] core_a;
   logic [N*DW-1:0] core_d;

   if (IN_REG) begin : g_inreg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            core_v <= '0;
            core_a <= '0;
            core_d <= '0;
         end else begin
            core_v <= in_valid;
            core_a <= in_addr;
            core_d <= in_data;
         end
      end
   end else begin : g_inwire
      assign core_v = in_valid;
      assign core_a = in_addr;
      assign core_d = in_data;
   end

   logic [N-1:0]    s_v, c_v, r_v, drop;
   logic [N*AW-1:0] s_a, s_src, c_a;
   logic [N*DW-1:0] s_d, c_d, r_d;
   logic            route_clash;

   fab_sorter #(.AW(AW), .DW(DW)) u_sort (
      .v_i(core_v), .a_i(core_a), .d_i(core_d),
      .v_o(s_v), .a_o(s_a), .src_o(s_src), .d_o(s_d)
   );

   fab_compact #(.AW(AW), .DW(DW)) u_compact (
      .v_i(s_v), .a_i(s_a), .src_i(s_src), .d_i(s_d),
      .v_o(c_v), .a_o(c_a), .d_o(c_d), .drop_o(drop)
   );

   fab_omega #(.AW(AW), .DW(DW)) u_route (
      .v_i(c_v), .a_i(c_a), .d_i(c_d),
      .v_o(r_v), .d_o(r_d), .clash_o(route_clash)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= '0;
         out_data  <= '0;
         in_reject <= '0;
      end else begin
         out_valid <= r_v;
         out_data  <= r_d;
         in_reject <= drop;
      end
   end
endmodule

// File: rtl/sortroute_fabric_chk.sv
module sortroute_fabric_chk #(
   parameter int AW = 3,
   localparam int N = 1 << AW
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N-1:0]    core_v,
   input logic [N*AW-1:0] core_a,
   input logic [N-1:0]    out_valid,
   input logic [N-1:0]    in_reject,
   input logic            clash
);
   logic [N-1:0] want_o, want_r, want_o_q, want_r_q, v_q;
   int           cnt_q;
   logic         live;

   always_comb begin
      want_o = '0;
      want_r = '0;
      for (int i = 0; i < N; i++) begin
         if (core_v[i]) begin
            if (want_o[core_a[i*AW +: AW]]) want_r[i] = 1'b1;
            else                            want_o[core_a[i*AW +: AW]] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         want_o_q <= '0;
         want_r_q <= '0;
         v_q      <= '0;
         cnt_q    <= 0;
         live     <= 1'b0;
      end else begin
         want_o_q <= want_o;
         want_r_q <= want_r;
         v_q      <= core_v;
         cnt_q    <= $countones(core_v);
         live     <= 1'b1;
      end
   end

   p_no_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clash);

   p_port_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (out_valid == want_o_q));

   p_low_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> (in_reject == want_r_q));

   p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> ((in_reject & ~v_q) == '0));

   p_conserve_r6: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> ($countones(out_valid) + $countones(in_reject) == cnt_q));
endmodule

bind sortroute_fabric sortroute_fabric_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .core_v(core_v), .core_a(core_a),
   .out_valid(out_valid), .in_reject(in_reject), .clash(route_clash)
);

// File: tb/sortroute_fabric_tb.sv
module sortroute_fabric_tb_top;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int N = 1 << AW;
   localparam bit IN_REG = 1'b1;
   localparam int LAT = 1 + int'(IN_REG);
   localparam int CLK_PERIOD = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    in_valid = '0;
   logic [N*AW-1:0] in_addr = '0;
   logic [N*DW-1:0] in_data = '0;
   logic [N-1:0]    out_valid;
   logic [N*DW-1:0] out_data;
   logic [N-1:0]    in_reject;

   int n_cmp = 0;
   int n_bad = 0;

   logic [N-1:0]    q_v[$];
   logic [N-1:0]    q_r[$];
   logic [N*DW-1:0] q_d[$];
   string           q_t[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sortroute_fabric #(.AW(AW), .DW(DW), .IN_REG(IN_REG)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
      .in_reject(in_reject)
   );

   task automatic chk(input string tag, input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Called at a falling edge: compare the oldest expectation, then drive
   // a new input pattern and queue its reference result.
   task automatic step(input logic [N-1:0] v, input logic [N*AW-1:0] a,
                       input logic [N*DW-1:0] d, input string tag);
      logic [N-1:0]    ev, er, pv, pr;
      logic [N*DW-1:0] ed, pd;
      string           pt;
      if (q_v.size() == LAT) begin
         pv = q_v.pop_front();
         pr = q_r.pop_front();
         pd = q_d.pop_front();
         pt = q_t.pop_front();
         chk({pt, " R2 R3 valid"}, N*DW'(out_valid), N*DW'(pv));
         chk({pt, " R3 R5 R7 data"}, out_data, pd);
         chk({pt, " R4 R5 reject"}, N*DW'(in_reject), N*DW'(pr));
         chk({pt, " R6 count"}, N*DW'($countones(out_valid) + $countones(in_reject)),
             N*DW'($countones(pv) + $countones(pr)));
      end
      ev = '0; er = '0; ed = '0;
      for (int i = 0; i < N; i++) begin
         if (v[i]) begin
            if (ev[a[i*AW +: AW]]) er[i] = 1'b1;
            else begin
               ev[a[i*AW +: AW]] = 1'b1;
               ed[a[i*AW +: AW]*DW +: DW] = d[i*DW +: DW];
            end
         end
      end
      q_v.push_back(ev); q_r.push_back(er); q_d.push_back(ed); q_t.push_back(tag);
      in_valid = v; in_addr = a; in_data = d;
      @(negedge clk);
   endtask

   function automatic logic [N*DW-1:0] tagged_data();
      logic [N*DW-1:0] d;
      for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'(($urandom() << AW) | i);
      return d;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [N-1:0]    v;
      logic [N*AW-1:0] a;
      // R1: reset state
      in_valid = '1;
      in_addr = '0;
      in_data = '1;
      repeat (3) @(negedge clk);
      chk("R1 valid", N*DW'(out_valid), '0);
      chk("R1 data", out_data, '0);
      chk("R1 reject", N*DW'(in_reject), '0);
      in_valid = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5: all idle
      step('0, '0, tagged_data(), "R5 idle");

      // R8: worked example
      v = 8'b0001_0110; a = '0;
      a[1*AW +: AW] = 3'd2; a[2*AW +: AW] = 3'd2; a[4*AW +: AW] = 3'd3;
      step(v, a, tagged_data(), "R8 example");

      // R9: every input to one port
      for (int p = 0; p < N; p++) begin
         a = '0;
         for (int i = 0; i < N; i++) a[i*AW +: AW] = AW'(p);
         step('1, a, tagged_data(), "R9 hotspot");
      end

      // R10: permutations, reversed and rotated
      for (int r = 0; r < N; r++) begin
         a = '0;
         for (int i = 0; i < N; i++) a[i*AW +: AW] = AW'((N - 1 - i + r) % N);
         step('1, a, tagged_data(), "R10 permutation");
      end

      // R3/R4: random traffic, full and narrow address ranges
      for (int c = 0; c < 600; c++) begin
         v = '0; a = '0;
         for (int i = 0; i < N; i++) begin
            v[i] = (($urandom() % 4) < (c % 4) + 1);
            if (c % 3 == 0) a[i*AW +: AW] = AW'($urandom() % 2);
            else            a[i*AW +: AW] = AW'($urandom());
         end
         step(v, a, tagged_data(), "R3 R4 random");
      end

      for (int k = 0; k < LAT; k++) step('0, '0, '0, "R5 drain");

      summary();
      $finish;
   end
endmodule